// File: doc/BRIEF.md
# Program Trace Capture Sequencer

This block records the program flow of a processor core into a small circular trace memory. The core presents one event per execution set that changes the flow. Each event carries a destination address, the condition flag, an event counter and an extension counter. While tracing is on, every accepted event produces one address entry. Depending on two mode bits, that entry is followed by one or two counter entries in the next cycles. Counter values are stored shifted left by one bit, so bit 0 of every entry works as a tag. Outside execution-set mode the tag tells an address from a counter. In execution-set mode the tag carries the condition flag.

A control register holds the enable and the mode bits. The mode bits are frozen while tracing is enabled. After a disable, a new enable is refused until a set number of execution sets have completed. These completions are signalled on `set_tick`. A debugger reads any entry through a registered read port, which also shows the write pointer and a sticky wrap flag.

Events use a valid/ready handshake. An event moves on a rising clock edge where `evt_valid` and `evt_ready` are both high. `evt_ready` drops while counter entries of the previous event are still being written. A producer holds its event and its data stable until the event is taken. The control, tick and debugger pins are plain strobes.

Top module: `trace_capture_top`

## Requirements
- R1: After reset, `cfg_rdata` reads 0, `dbg_wr_ptr` is 0 and `dbg_wrapped` is 0.
- R2: The control bits are: bit 0 kind, bit 1 flow option, bit 2 interrupt trace, bit 3 execution-set mode, bit 4 mark, bit 5 enable, bit 6 counter mode and bit 7 extension mode. A write while disabled stores all eight bits, subject to R4. Bits 15:8 of `cfg_rdata` always read 0.
- R3: While enable is 1, a write leaves bits 7:6 and 4:0 unchanged and only updates enable.
- R4: When enable goes from 1 to 0, a reload of enable is refused until 5 `set_tick` pulses have been counted after the disable. A refused write still stores the mode bits.
- R5: While enable is 0, `evt_ready` is 1 and accepted events write no entry, so `dbg_wr_ptr` is unchanged.
- R6: An accepted event writes `{evt_addr[31:1], b0}` in the cycle it is accepted. b0 is 0 unless execution-set mode is on.
- R7: With counter mode on, the next entry is `{evt_cnt, b0}`. With extension mode on, an entry `{evt_cntx, b0}` follows after that. Each extra entry takes one cycle. In these entries b0 is 1 outside execution-set mode, so the value 0x8 is stored as 0x11.
- R8: In execution-set mode, bit 0 of every entry of an event equals the `evt_cond` value that came with that event.
- R9: `evt_ready` is 0 in every cycle in which a counter entry of an earlier event is pending.
- R10: `dbg_wr_ptr` advances by one for each entry and wraps from 63 to 0. `dbg_wrapped` becomes 1 at the first wrap and stays 1 until reset.
- R11: When `dbg_rd_en` is high at a clock edge, `dbg_rd_valid` is high after that edge and `dbg_rd_data` holds the entry at `dbg_rd_idx`. Otherwise `dbg_rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 16 | Control register contents |
| set_tick | input | 1 | One pulse per completed execution set |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event can be taken |
| evt_addr | input | 31 | Destination address bits 31:1 |
| evt_cond | input | 1 | Condition flag of the execution set |
| evt_cnt | input | 31 | Event counter value |
| evt_cntx | input | 31 | Extension counter value |
| dbg_rd_en | input | 1 | Debugger read strobe |
| dbg_rd_idx | input | 6 | Entry index to read |
| dbg_rd_valid | output | 1 | Read data valid |
| dbg_rd_data | output | 32 | Read entry |
| dbg_wr_ptr | output | 6 | Next entry to be written |
| dbg_wrapped | output | 1 | Sticky wrap flag |

## Verification
The assertions assume that no control write changes the mode bits while the counter entries of an event are still being written. They also assume that a debugger never reads the index being written in the same cycle. The stimulus keeps to both: it waits several idle cycles after each event before it reconfigures or reads. The stimulus also holds every event until it is taken, and it drives `set_tick` only as single-cycle pulses. This keeps the lockout count at exactly one per pulse.

// File: rtl/trace_pkg.sv
package trace_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CNT  = 2'd1,
    SQ_CNTX = 2'd2
  } sq_state_e;

  // Packed most significant first: bit 7 down to bit 0.
  typedef struct packed {
    logic cntx_mode;
    logic cnt_mode;
    logic en;
    logic mark;
    logic exec;
    logic irq;
    logic chof;
    logic kind;
  } ctl_t;

  localparam logic [7:0] CTL_MODE_MASK = 8'hDF;

endpackage

// File: rtl/trace_ctrl_reg.sv
module trace_ctrl_reg
  import trace_pkg::*;
#(
  parameter int LOCK_SETS = 5,
  localparam int LCW = $clog2(LOCK_SETS + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [7:0]  wdata,
  input  logic        set_tick,
  output ctl_t        ctl,
  output logic [15:0] rdata
);

  ctl_t           cur, nxt, wr;
  logic [LCW-1:0] lock_cnt;
  logic           lock_free;

  assign wr        = ctl_t'(wdata);
  assign lock_free = (lock_cnt == '0);

  always_comb begin
    nxt = cur;
    if (we) begin
      if (cur.en) begin
        nxt.en = wr.en;
      end else begin
        nxt    = wr;
        nxt.en = wr.en && lock_free;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= '0;
      lock_cnt <= '0;
    end else begin
      cur <= nxt;
      if (cur.en && !nxt.en)
        lock_cnt <= LCW'(LOCK_SETS);
      else if (set_tick && !lock_free)
        lock_cnt <= lock_cnt - LCW'(1);
    end
  end

  assign ctl   = cur;
  assign rdata = {8'h00, cur};

  // R3
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cur.en) |-> ((cur & CTL_MODE_MASK) == ($past(cur) & CTL_MODE_MASK)));

  // R4
  relock_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cur.en) |-> ($past(lock_cnt) == '0));

endmodule

// File: rtl/trace_seq_fsm.sv
module trace_seq_fsm
  import trace_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          exec_mode,
  input  logic          cnt_mode,
  input  logic          cntx_mode,
  input  logic          evt_valid,
  output logic          evt_ready,
  input  logic [DW-1:1] evt_addr,
  input  logic          evt_cond,
  input  logic [DW-2:0] evt_cnt,
  input  logic [DW-2:0] evt_cntx,
  output logic          ent_we,
  output logic [DW-1:0] ent_data
);

  sq_state_e     state, nstate;
  logic [DW-2:0] cnt_l, cntx_l;
  logic          x_l, tag_l;
  logic          take;

  assign evt_ready = (state == SQ_IDLE);
  assign take      = evt_valid && evt_ready && en;

  always_comb begin
    nstate   = state;
    ent_we   = 1'b0;
    ent_data = '0;
    unique case (state)
      SQ_IDLE: begin
        if (take) begin
          ent_we   = 1'b1;
          ent_data = {evt_addr, exec_mode ? evt_cond : 1'b0};
          if (cnt_mode)       nstate = SQ_CNT;
          else if (cntx_mode) nstate = SQ_CNTX;
        end
      end
      SQ_CNT: begin
        ent_we   = 1'b1;
        ent_data = {cnt_l, tag_l};
        nstate   = x_l ? SQ_CNTX : SQ_IDLE;
      end
      SQ_CNTX: begin
        ent_we   = 1'b1;
        ent_data = {cntx_l, tag_l};
        nstate   = SQ_IDLE;
      end
      default: nstate = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      cnt_l  <= '0;
      cntx_l <= '0;
      x_l    <= 1'b0;
      tag_l  <= 1'b0;
    end else begin
      state <= nstate;
      if (take) begin
        cnt_l  <= evt_cnt;
        cntx_l <= evt_cntx;
        x_l    <= cntx_mode;
        tag_l  <= exec_mode ? evt_cond : 1'b1;
      end
    end
  end

  // R9
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (cnt_mode || cntx_mode)) |=> (ent_we && !evt_ready));

  // R7
  cnt_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cnt_mode && !exec_mode) |=> (ent_data[0] && ent_data[DW-1:1] == $past(evt_cnt)));

  // R8
  exec_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && exec_mode && (cnt_mode || cntx_mode)) |=> (ent_data[0] == $past(evt_cond)));

endmodule

// File: rtl/trace_store.sv
module trace_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] wr_ptr,
  output logic          wrapped
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic          at_last;

  assign at_last = (wr_ptr == LAST);

  always_ff @(posedge clk) begin
    if (we) mem[wr_ptr] <= wdata;
    if (rd_en) rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      wrapped  <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (we) begin
        wr_ptr <= at_last ? '0 : wr_ptr + AW'(1);
        if (at_last) wrapped <= 1'b1;
      end
    end
  end

  // R10
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we) && $past(wr_ptr) != LAST) |-> (wr_ptr == $past(wr_ptr) + AW'(1)));

  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we) |-> $stable(wr_ptr));

  // R10
  wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wrapped) |-> wrapped);

  // R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en) |-> rd_valid);

endmodule

// File: rtl/trace_capture_top.sv
module trace_capture_top
  import trace_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int DW        = 32,
  parameter int LOCK_SETS = 5,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic [15:0]   cfg_rdata,
  input  logic          set_tick,
  input  logic          evt_valid,
  output logic          evt_ready,
  input  logic [DW-1:1] evt_addr,
  input  logic          evt_cond,
  input  logic [DW-2:0] evt_cnt,
  input  logic [DW-2:0] evt_cntx,
  input  logic          dbg_rd_en,
  input  logic [AW-1:0] dbg_rd_idx,
  output logic          dbg_rd_valid,
  output logic [DW-1:0] dbg_rd_data,
  output logic [AW-1:0] dbg_wr_ptr,
  output logic          dbg_wrapped
);

  ctl_t          ctl;
  logic          ent_we;
  logic [DW-1:0] ent_data;

  trace_ctrl_reg #(.LOCK_SETS(LOCK_SETS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .set_tick (set_tick),
    .ctl      (ctl),
    .rdata    (cfg_rdata)
  );

  trace_seq_fsm #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctl.en),
    .exec_mode (ctl.exec),
    .cnt_mode  (ctl.cnt_mode),
    .cntx_mode (ctl.cntx_mode),
    .evt_valid (evt_valid),
    .evt_ready (evt_ready),
    .evt_addr  (evt_addr),
    .evt_cond  (evt_cond),
    .evt_cnt   (evt_cnt),
    .evt_cntx  (evt_cntx),
    .ent_we    (ent_we),
    .ent_data  (ent_data)
  );

  trace_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ent_we),
    .wdata    (ent_data),
    .rd_en    (dbg_rd_en),
    .rd_idx   (dbg_rd_idx),
    .rd_data  (dbg_rd_data),
    .rd_valid (dbg_rd_valid),
    .wr_ptr   (dbg_wr_ptr),
    .wrapped  (dbg_wrapped)
  );

endmodule

// File: tb/trace_capture_top_test.sv
`timescale 1ns/1ps
module trace_capture_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        set_tick = 1'b0;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [31:1] evt_addr = '0;
  logic        evt_cond = 1'b0;
  logic [30:0] evt_cnt = '0;
  logic [30:0] evt_cntx = '0;
  logic        dbg_rd_en = 1'b0;
  logic [5:0]  dbg_rd_idx = '0;
  logic        dbg_rd_valid;
  logic [31:0] dbg_rd_data;
  logic [5:0]  dbg_wr_ptr;
  logic        dbg_wrapped;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] exp_mem [64];
  int          exp_ptr = 0;
  bit          m_en = 0, m_exec = 0, m_cnt = 0, m_cntx = 0;
  logic [31:0] exp_q [$];
  string       req_q [$];

  always #2.5 clk = ~clk;

  trace_capture_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .set_tick(set_tick), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_addr(evt_addr), .evt_cond(evt_cond),
    .evt_cnt(evt_cnt), .evt_cntx(evt_cntx), .dbg_rd_en(dbg_rd_en),
    .dbg_rd_idx(dbg_rd_idx), .dbg_rd_valid(dbg_rd_valid),
    .dbg_rd_data(dbg_rd_data), .dbg_wr_ptr(dbg_wr_ptr), .dbg_wrapped(dbg_wrapped)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); set_tick = 1'b1;
      @(negedge clk); set_tick = 1'b0;
    end
  endtask

  task automatic push_exp(input logic [31:0] v);
    exp_mem[exp_ptr] = v;
    exp_ptr = (exp_ptr + 1) % 64;
  endtask

  // Driver: offers one event, waits for the handshake, updates the model.
  task automatic send(input logic [31:0] addr, input bit cond, input logic [30:0] c, input logic [30:0] cx);
    @(negedge clk);
    evt_valid = 1'b1; evt_addr = addr[31:1]; evt_cond = cond; evt_cnt = c; evt_cntx = cx;
    while (!evt_ready) @(negedge clk);
    if (m_en) begin
      push_exp({addr[31:1], m_exec ? cond : 1'b0});
      if (m_cnt)  push_exp({c,  m_exec ? cond : 1'b1});
      if (m_cntx) push_exp({cx, m_exec ? cond : 1'b1});
    end
    @(negedge clk); evt_valid = 1'b0;
  endtask

  task automatic read_entry(input int idx, input string req);
    @(negedge clk);
    dbg_rd_en = 1'b1; dbg_rd_idx = 6'(idx);
    exp_q.push_back(exp_mem[idx]); req_q.push_back(req);
    @(negedge clk); dbg_rd_en = 1'b0;
  endtask

  task automatic reenable(input logic [7:0] v);
    cfg_write(8'h00); m_en = 0;
    tick(5);
    cfg_write(v);
    m_en = v[5]; m_exec = v[3]; m_cnt = v[6]; m_cntx = v[7];
  endtask

  // Monitor: pops the scoreboard whenever read data comes back (R11).
  always @(negedge clk) begin
    if (rst_n && dbg_rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected read data", dbg_rd_data, 32'h0);
      end else begin
        logic [31:0] e;
        string r;
        e = exp_q.pop_front(); r = req_q.pop_front();
        check(dbg_rd_data == e, r, dbg_rd_data, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cfg_rdata == 16'h0, "R1 cfg", 32'(cfg_rdata), 0);
    check(dbg_wr_ptr == 6'd0, "R1 ptr", 32'(dbg_wr_ptr), 0);
    check(dbg_wrapped == 1'b0, "R1 wrapped", 32'(dbg_wrapped), 0);

    // R2 layout, upper byte reads zero
    cfg_write(8'h17);
    check(cfg_rdata == 16'h0017, "R2 mode bits stored", 32'(cfg_rdata), 32'h17);
    cfg_write(8'h20); m_en = 1;
    check(cfg_rdata == 16'h0020, "R2 enable set", 32'(cfg_rdata), 32'h20);

    // R6 plain address entries, bit 0 cleared
    send(32'h0000_1235, 1'b1, 31'd7, 31'd9);
    send(32'hFFFF_FFFE, 1'b0, 31'd1, 31'd2);
    send(32'h8000_0001, 1'b1, 31'd3, 31'd4);
    repeat (2) @(negedge clk);
    check(dbg_wr_ptr == 6'd3, "R10 ptr after three", 32'(dbg_wr_ptr), 3);

    // R3 mode change refused while enabled
    cfg_write(8'hE8);
    check(cfg_rdata == 16'h0020, "R3 modes locked", 32'(cfg_rdata), 32'h20);

    // R5 events ignored while disabled
    cfg_write(8'h00); m_en = 0;
    @(negedge clk);
    check(evt_ready == 1'b1, "R5 ready while off", 32'(evt_ready), 1);
    send(32'h0000_4444, 1'b0, 31'd5, 31'd6);
    repeat (3) @(negedge clk);
    check(dbg_wr_ptr == 6'd3, "R5 no entry while off", 32'(dbg_wr_ptr), 3);

    // R4 relock gap
    cfg_write(8'h60);
    check(cfg_rdata == 16'h0040, "R4 refused at once", 32'(cfg_rdata), 32'h40);
    tick(4);
    cfg_write(8'h60);
    check(cfg_rdata == 16'h0040, "R4 refused after 4", 32'(cfg_rdata), 32'h40);
    tick(1);
    cfg_write(8'h60);
    check(cfg_rdata == 16'h0060, "R4 accepted after 5", 32'(cfg_rdata), 32'h60);
    m_en = 1; m_cnt = 1; m_cntx = 0; m_exec = 0;

    // R7 counter entry, value 8 becomes 0x11
    send(32'h0000_0100, 1'b0, 31'h8, 31'd5);
    check(evt_ready == 1'b0, "R9 stall during counter", 32'(evt_ready), 0);
    repeat (2) @(negedge clk);

    // R7 both counters, order
    reenable(8'hE0);
    send(32'h0000_0200, 1'b0, 31'h3, 31'h7FFF_FFFF);
    check(evt_ready == 1'b0, "R9 stall first", 32'(evt_ready), 0);
    @(negedge clk);
    check(evt_ready == 1'b0, "R9 stall second", 32'(evt_ready), 0);
    repeat (2) @(negedge clk);

    // R8 execution-set mode with extension counter
    reenable(8'hA8);
    send(32'h0000_0301, 1'b1, 31'd0, 31'd2);
    repeat (3) @(negedge clk);
    send(32'h0000_0300, 1'b0, 31'd0, 31'd2);
    repeat (3) @(negedge clk);
    check(dbg_wr_ptr == 6'd12, "R10 ptr after groups", 32'(dbg_wr_ptr), 12);

    for (int i = 0; i < 3; i++) read_entry(i, "R6 address entry");
    read_entry(3, "R7 addr before counter");
    read_entry(4, "R7 counter 0x8 as 0x11");
    read_entry(5, "R7 addr first");
    read_entry(6, "R7 event counter second");
    read_entry(7, "R7 extension counter third");
    for (int i = 8; i < 12; i++) read_entry(i, "R8 condition tag");
    @(negedge clk);
    check(exp_mem[4] == 32'h11, "R7 model sanity", exp_mem[4], 32'h11);

    // R10 wrap
    reenable(8'h20);
    for (int i = 0; i < 51; i++) send(32'h0001_0000 + 32'(i * 2), 1'b0, 31'd0, 31'd0);
    repeat (2) @(negedge clk);
    check(dbg_wr_ptr == 6'd63, "R10 ptr at last", 32'(dbg_wr_ptr), 63);
    check(dbg_wrapped == 1'b0, "R10 not yet wrapped", 32'(dbg_wrapped), 0);
    for (int i = 0; i < 3; i++) send(32'h0002_0000 + 32'(i * 2), 1'b0, 31'd0, 31'd0);
    repeat (2) @(negedge clk);
    check(dbg_wr_ptr == 6'd2, "R10 ptr wrapped", 32'(dbg_wr_ptr), 2);
    check(dbg_wrapped == 1'b1, "R10 wrapped set", 32'(dbg_wrapped), 1);
    read_entry(63, "R10 last slot");
    read_entry(0, "R10 overwritten slot 0");
    read_entry(1, "R10 overwritten slot 1");
    send(32'h0003_0000, 1'b0, 31'd0, 31'd0);
    repeat (2) @(negedge clk);
    check(dbg_wrapped == 1'b1, "R10 wrapped sticky", 32'(dbg_wrapped), 1);

    // R11 no valid without a read
    repeat (2) @(negedge clk);
    check(dbg_rd_valid == 1'b0, "R11 idle valid low", 32'(dbg_rd_valid), 0);
    check(exp_q.size() == 0, "R11 all reads returned", 32'(exp_q.size()), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule